// File: doc/BRIEF.md
# Frame Pulse and Active Window Generator

This block supplies the vertical half of a panel driver's timing. A line counter moves forward by one on every line-end strobe from the horizontal timing generator. It returns to zero once it reaches the last line of a programmable frame period. From that count the block drives three frame-rate pulses. Each pulse has its own programmable first line, stop line and output polarity.

Two of the pulses can be merged with line-rate load pulses from the horizontal side. Pulse 2 can be gated by an AND with load pulse A. Pulse 3 can be widened by an OR with load pulse B. Both merges act on positive-sense signals, and the polarity bit is applied after the merge.

The block also drives a data-enable output. This output marks the active image rectangle. It is bounded horizontally by pixel positions and vertically by line positions. Vertical settings are copied into shadow registers at each frame wrap, so a frame in progress never changes shape. The copy also happens on the first clock after reset.

Top module: `frame_timing_gen`

## Requirements
- R1: While reset is asserted and on the first clock after release, `line_cnt` is 0. The vertical shadow registers load from the ports on that first clock.
- R2: `line_cnt` increments only in a cycle where `line_end` is 1. On the strobe where `line_cnt` equals shadowed `frame_len`-1, it returns to 0 instead.
- R3: With a shadowed `frame_len` of 0 or 1, `line_cnt` stays at 0 through every strobe.
- R4: The positive-sense frame pulse n is active for lines L with start ≤ L < stop, when start < stop. It uses the shadowed `fpN_start` and `fpN_stop`.
- R5: When start > stop, the pulse is active for L ≥ start or L < stop, wrapping across the frame boundary. When start = stop, the pulse is never active.
- R6: An output pin is the positive-sense pulse when `fpN_inv` is 0, and its complement when `fpN_inv` is 1. `fpN_inv` is live and not shadowed.
- R7: When `mix_and` is 1, the positive-sense pulse 2 is ANDed with `load_a` before polarity is applied. When `mix_and` is 0, `load_a` has no effect on `fp2`.
- R8: When `mix_or` is 1, the positive-sense pulse 3 is ORed with `load_b` before polarity is applied. When `mix_or` is 0, `load_b` has no effect on `fp3`.
- R9: `de` is 1 exactly when `act_h_start` ≤ `hcount` ≤ `act_h_end` and the shadowed `act_v_start` ≤ `line_cnt` ≤ the shadowed `act_v_end`. Both comparisons are inclusive. The horizontal bounds are live.
- R10: Frame length, pulse start/stop lines and vertical active bounds reach the shadows only on a wrapping strobe, or on the first clock after reset. Changes at other times have no effect until then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_end | input | 1 | One-cycle end-of-line strobe |
| hcount | input | 11 | Current pixel position |
| load_a | input | 1 | Positive-sense load pulse merged into pulse 2 |
| load_b | input | 1 | Positive-sense load pulse merged into pulse 3 |
| frame_len | input | 10 | Frame period in lines |
| fp1_start | input | 10 | Pulse 1 first line |
| fp1_stop | input | 10 | Pulse 1 stop line (exclusive) |
| fp1_inv | input | 1 | Pulse 1 polarity, 1 = negative |
| fp2_start | input | 10 | Pulse 2 first line |
| fp2_stop | input | 10 | Pulse 2 stop line (exclusive) |
| fp2_inv | input | 1 | Pulse 2 polarity, 1 = negative |
| fp3_start | input | 10 | Pulse 3 first line |
| fp3_stop | input | 10 | Pulse 3 stop line (exclusive) |
| fp3_inv | input | 1 | Pulse 3 polarity, 1 = negative |
| mix_and | input | 1 | Enable AND merge of pulse 2 with load_a |
| mix_or | input | 1 | Enable OR merge of pulse 3 with load_b |
| act_h_start | input | 11 | First active pixel |
| act_h_end | input | 11 | Last active pixel |
| act_v_start | input | 10 | First active line |
| act_v_end | input | 10 | Last active line |
| line_cnt | output | 10 | Current line number |
| fp1 | output | 1 | Frame pulse 1 |
| fp2 | output | 1 | Frame pulse 2 |
| fp3 | output | 1 | Frame pulse 3 |
| de | output | 1 | Active image data enable |

## Verification
The first pattern uses fixed settings, with ordinary, wrapping and empty pulse windows on a short frame. This separates the three window cases and the wrap point of the counter. Later patterns turn on inversion and feed random load pulses with each merge on and off. These show whether polarity is applied after the merge, and whether a disabled merge leaks.

Frame lengths of 0 and 1 probe the degenerate wrap. Register values are rewritten at random moments in the middle of a frame. Any mismatch there shows that a shadow was updated at the wrong time. Random pixel counts around narrow windows test the inclusive edges of the data-enable window.

// File: rtl/frame_timing_gen.sv
module frame_timing_gen #(
  parameter int LW = 10,
  parameter int PW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_end,
  input  logic [PW-1:0] hcount,
  input  logic          load_a,
  input  logic          load_b,
  input  logic [LW-1:0] frame_len,
  input  logic [LW-1:0] fp1_start,
  input  logic [LW-1:0] fp1_stop,
  input  logic          fp1_inv,
  input  logic [LW-1:0] fp2_start,
  input  logic [LW-1:0] fp2_stop,
  input  logic          fp2_inv,
  input  logic [LW-1:0] fp3_start,
  input  logic [LW-1:0] fp3_stop,
  input  logic          fp3_inv,
  input  logic          mix_and,
  input  logic          mix_or,
  input  logic [PW-1:0] act_h_start,
  input  logic [PW-1:0] act_h_end,
  input  logic [LW-1:0] act_v_start,
  input  logic [LW-1:0] act_v_end,
  output logic [LW-1:0] line_cnt,
  output logic          fp1,
  output logic          fp2,
  output logic          fp3,
  output logic          de
);

  logic [LW-1:0] len_s, s1, e1, s2, e2, s3, e3, vs_s, ve_s;
  logic          first;
  logic          wrap;
  logic          p1, p2, p3;

  assign wrap = ({1'b0, line_cnt} + 1'b1) >= {1'b0, len_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_cnt <= '0;
      first    <= 1'b1;
      len_s <= '0; vs_s <= '0; ve_s <= '0;
      s1 <= '0; e1 <= '0; s2 <= '0; e2 <= '0; s3 <= '0; e3 <= '0;
    end else begin
      first <= 1'b0;
      if (line_end)
        line_cnt <= wrap ? '0 : line_cnt + 1'b1;
      if (first || (line_end && wrap)) begin
        len_s <= frame_len;
        vs_s  <= act_v_start;
        ve_s  <= act_v_end;
        s1 <= fp1_start; e1 <= fp1_stop;
        s2 <= fp2_start; e2 <= fp2_stop;
        s3 <= fp3_start; e3 <= fp3_stop;
      end
    end
  end

  function automatic logic in_win(input logic [LW-1:0] l, st, sp);
    if (st < sp) return (l >= st) && (l < sp);
    if (st > sp) return (l >= st) || (l < sp);
    return 1'b0;
  endfunction

  assign p1 = in_win(line_cnt, s1, e1);
  assign p2 = in_win(line_cnt, s2, e2) & (~mix_and | load_a);
  assign p3 = in_win(line_cnt, s3, e3) | (mix_or & load_b);

  assign fp1 = p1 ^ fp1_inv;
  assign fp2 = p2 ^ fp2_inv;
  assign fp3 = p3 ^ fp3_inv;

  assign de = (hcount >= act_h_start) && (hcount <= act_h_end) &&
              (line_cnt >= vs_s) && (line_cnt <= ve_s);

  // R2
  hold_without_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !line_end |=> $stable(line_cnt));

  // R2
  count_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (len_s <= 1) ? (line_cnt == 0) : (line_cnt < len_s));

  // R5
  empty_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s1 == e1 && !fp1_inv) |-> !fp1);

  // R7
  and_mix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mix_and && !load_a && !fp2_inv) |-> !fp2);

  // R8
  or_mix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mix_or && load_b && !fp3_inv) |-> fp3);

  // R9
  de_horiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> (hcount >= act_h_start && hcount <= act_h_end));

endmodule

// File: tb/sim_frame_timing_gen.sv
`timescale 1ns/1ps
module sim_frame_timing_gen;
  logic clk = 0, rst_n = 0, line_end = 0, load_a = 0, load_b = 0;
  logic [10:0] hcount = 0, hs = 0, he = 0;
  logic [9:0] flen = 0, a1 = 0, b1 = 0, a2 = 0, b2 = 0, a3 = 0, b3 = 0, vs = 0, ve = 0;
  logic i1 = 0, i2 = 0, i3 = 0, mxa = 0, mxo = 0;
  logic [9:0] line_cnt;
  logic fp1, fp2, fp3, de;

  always #4 clk = ~clk;

  frame_timing_gen u0 (
    .clk(clk), .rst_n(rst_n), .line_end(line_end), .hcount(hcount),
    .load_a(load_a), .load_b(load_b), .frame_len(flen),
    .fp1_start(a1), .fp1_stop(b1), .fp1_inv(i1),
    .fp2_start(a2), .fp2_stop(b2), .fp2_inv(i2),
    .fp3_start(a3), .fp3_stop(b3), .fp3_inv(i3),
    .mix_and(mxa), .mix_or(mxo),
    .act_h_start(hs), .act_h_end(he), .act_v_start(vs), .act_v_end(ve),
    .line_cnt(line_cnt), .fp1(fp1), .fp2(fp2), .fp3(fp3), .de(de));

  int vectors = 0, errors = 0;
  string phase = "R1";
  bit done = 0;

  // behavioural reference
  int m_line, m_len, m_s[3], m_e[3], m_vs, m_ve;
  bit m_first;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_line = 0; m_first = 1; m_len = 0; m_vs = 0; m_ve = 0;
      foreach (m_s[k]) begin m_s[k] = 0; m_e[k] = 0; end
    end else begin
      bit w;
      w = (m_line + 1 >= m_len);
      if (line_end) m_line = w ? 0 : m_line + 1;
      if (m_first || (line_end && w)) begin
        m_len = flen; m_vs = vs; m_ve = ve;
        m_s[0] = a1; m_e[0] = b1; m_s[1] = a2; m_e[1] = b2; m_s[2] = a3; m_e[2] = b3;
      end
      m_first = 0;
    end
  end

  function automatic bit active(int l, int st, int sp);
    if (st < sp) return l >= st && l < sp;
    if (st > sp) return l >= st || l < sp;
    return 0;
  endfunction

  task automatic cmp(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s [%s] actual=%0d expected=%0d t=%0t", tag, phase, act, exp, $time);
    end
  endtask

  task automatic check_all();
    bit q1, q2, q3, qd;
    q1 = active(m_line, m_s[0], m_e[0]) ^ i1;
    q2 = (active(m_line, m_s[1], m_e[1]) & (!mxa | load_a)) ^ i2;
    q3 = (active(m_line, m_s[2], m_e[2]) | (mxo & load_b)) ^ i3;
    qd = hcount >= hs && hcount <= he && m_line >= m_vs && m_line <= m_ve;
    cmp("R2 line_cnt", line_cnt, m_line);
    cmp("R4 fp1", fp1, q1);
    cmp("R7 fp2", fp2, q2);
    cmp("R8 fp3", fp3, q3);
    cmp("R9 de", de, qd);
  endtask

  task automatic run(int n, int gap, bit rnd_load, bit rnd_regs);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      check_all();
      line_end = (gap == 0) ? ($urandom_range(0, 3) == 0) : ((c % gap) == gap - 1);
      hcount = $urandom_range(0, 40);
      if (rnd_load) begin load_a = $urandom_range(0, 1); load_b = $urandom_range(0, 1); end
      if (rnd_regs && $urandom_range(0, 30) == 0) begin
        flen = $urandom_range(0, 14);
        a1 = $urandom_range(0, 12); b1 = $urandom_range(0, 12);
        a2 = $urandom_range(0, 12); b2 = $urandom_range(0, 12);
        a3 = $urandom_range(0, 12); b3 = $urandom_range(0, 12);
        vs = $urandom_range(0, 10); ve = $urandom_range(0, 12);
        hs = $urandom_range(0, 30); he = $urandom_range(5, 40);
        i1 = $urandom_range(0, 1); i2 = $urandom_range(0, 1); i3 = $urandom_range(0, 1);
        mxa = $urandom_range(0, 1); mxo = $urandom_range(0, 1);
      end
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    flen = 8; a1 = 2; b1 = 5; a2 = 6; b2 = 2; a3 = 3; b3 = 3;
    vs = 1; ve = 4; hs = 10; he = 20;
    repeat (3) @(negedge clk);
    phase = "R1 reset";
    cmp("R1 line_cnt in reset", line_cnt, 0);
    rst_n = 1;
    run(2, 1000, 0, 0);
    cmp("R1 line_cnt after release", line_cnt, 0);
    phase = "R2/R4/R5 fixed windows";
    run(400, 4, 0, 0);
    phase = "R6 inverted";
    i1 = 1; i2 = 1; i3 = 1;
    run(300, 3, 0, 0);
    phase = "R7/R8 mix on";
    mxa = 1; mxo = 1; i2 = 0; i3 = 0;
    run(300, 0, 1, 0);
    phase = "R7/R8 mix off, loads toggling";
    mxa = 0; mxo = 0;
    run(200, 0, 1, 0);
    phase = "R3 frame_len 0";
    flen = 0;
    run(120, 2, 0, 0);
    phase = "R3 frame_len 1";
    flen = 1;
    run(120, 2, 0, 0);
    phase = "R9 narrow window";
    flen = 12; vs = 3; ve = 3; hs = 15; he = 15;
    run(400, 0, 0, 0);
    phase = "R10 mid-frame rewrites";
    run(6000, 0, 1, 1);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule